// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block is the host-visible register bank of a two-channel bus-master disk DMA function. It decodes byte-wide reads and writes inside one small I/O region. Each channel owns an 8-byte window. The window holds a command byte, a status byte and a 32-bit pointer to the channel's descriptor table. Reads are combinational from the address. Writes take effect at the clock edge that samples `host_wr`.

On the engine side, the block presents the run and direction bits and the aligned table pointer of each channel. It also gives a one-cycle stop pulse when software clears the run bit. The DMA engine feeds back an active level and two set pulses, for error and interrupt. The status byte mixes several kinds of bit. Two bits are plain read/write, two bits are cleared by writing one and set by the engine, one bit mirrors the engine and cannot be written, and the rest read as zero.

Top module: `bmdma_regbank`

## Requirements
- R1: After reset the command, status and all four pointer bytes of every channel read 0x00, and the run, direction and stop outputs are 0.
- R2: Offsets 1 and 3 of a channel window read 0xFF. A write to either offset leaves every register unchanged.
- R3: A write to offset 0 keeps only bit 0 (run, output `cmd_run`) and bit 3 (direction, output `cmd_dir`). The other bits read back as 0.
- R4: A command write that changes bit 0 from 1 to 0 raises `cmd_stop` for exactly the one cycle after the write. A command write that does not clear a set run bit gives no pulse.
- R5: A status write (offset 2) loads bits 5 and 6 with the written values.
- R6: In a status write, a 1 written to bit 1 or bit 2 clears that bit, and a 0 written there leaves it unchanged.
- R7: Status bit 0 shows the `eng_active` level sampled one edge earlier. Writing status never changes it.
- R8: Status bits 3, 4 and 7 always read 0.
- R9: A pulse on `eng_err_set` sets status bit 1, and a pulse on `eng_irq_set` sets status bit 2, from the next edge on. When such a set and a host clear of the same bit fall in the same cycle, the bit ends up set.
- R10: Offsets 4..7 hold the table pointer in little-endian order: offset 4 is bits 7:0 and offset 7 is bits 31:24. Bits 1:0 are always stored as 0, and the pointer appears on `tbl_addr`.
- R11: Channel n occupies offsets 8n..8n+7. Accesses to one channel never alter another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Byte offset inside the register region |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data byte for `host_addr` |
| eng_active | input | 2 | Per-channel engine busy level |
| eng_err_set | input | 2 | Per-channel error set pulse |
| eng_irq_set | input | 2 | Per-channel interrupt set pulse |
| cmd_run | output | 2 | Per-channel run bit |
| cmd_dir | output | 2 | Per-channel direction bit |
| cmd_stop | output | 2 | Per-channel one-cycle stop pulse |
| tbl_addr | output | 64 | Descriptor table pointers, channel 0 in bits 31:0 |

## Verification
The checker assumes three things about its inputs. The engine set inputs are pulses that are sampled at clock edges. `eng_active` is held low during reset. Every host access is a single-cycle strobe whose address and data are stable around the edge. The bench drives every input on the falling edge and releases each pulse after one cycle. It keeps the engine inputs low through reset, so each edge sees exactly one clean request.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 32;

  // bit positions inside the command and status bytes
  localparam int unsigned CMD_RUN = 0;
  localparam int unsigned CMD_DIR = 3;
  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_IRQ  = 2;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_PTR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // keep only the implemented command bits
  function automatic logic [BYTE_W-1:0] cmd_mask(input logic [BYTE_W-1:0] w);
    logic [BYTE_W-1:0] r;
    r = '0;
    r[CMD_RUN] = w[CMD_RUN];
    r[CMD_DIR] = w[CMD_DIR];
    return r;
  endfunction

  // next status byte: host write rules merged with engine events
  function automatic logic [BYTE_W-1:0] stat_next(
    input logic [BYTE_W-1:0] cur,
    input logic              we,
    input logic [BYTE_W-1:0] w,
    input logic              err_set,
    input logic              irq_set,
    input logic              active
  );
    logic [BYTE_W-1:0] r;
    r = '0;
    r[6:5]    = we ? w[6:5] : cur[6:5];
    r[ST_ERR] = (cur[ST_ERR] & ~(we & w[ST_ERR])) | err_set;
    r[ST_IRQ] = (cur[ST_IRQ] & ~(we & w[ST_IRQ])) | irq_set;
    r[ST_ACT] = active;
    return r;
  endfunction

  // replace one byte of the pointer, force dword alignment
  function automatic logic [PTR_W-1:0] ptr_merge(
    input logic [PTR_W-1:0]  cur,
    input logic [1:0]        lane,
    input logic [BYTE_W-1:0] w
  );
    logic [PTR_W-1:0] r;
    r = cur;
    r[lane*BYTE_W +: BYTE_W] = w;
    r[1:0] = 2'b00;
    return r;
  endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned CH_W = 1,
  parameter int unsigned OFF_W = 3,
  localparam int unsigned AW  = CH_W + OFF_W
) (
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  output logic [CH_W-1:0] ch_idx,
  output logic            ch_ok,
  output reg_sel_e        sel,
  output logic [1:0]      lane,
  output logic [NCH-1:0]  cmd_we,
  output logic [NCH-1:0]  stat_we,
  output logic [NCH-1:0]  ptr_we
);
  logic [OFF_W-1:0] off;

  assign ch_idx = addr[AW-1:OFF_W];
  assign off    = addr[OFF_W-1:0];
  assign lane   = off[1:0];

  generate
    if (NCH == (1 << CH_W)) begin : g_full
      assign ch_ok = 1'b1;
    end else begin : g_part
      assign ch_ok = ({1'b0, ch_idx} < (CH_W+1)'(NCH));
    end
  endgenerate

  always_comb begin
    if (off[2])            sel = SEL_PTR;
    else if (off == 3'd0)  sel = SEL_CMD;
    else if (off == 3'd2)  sel = SEL_STAT;
    else                   sel = SEL_NONE;
  end

  always_comb begin
    cmd_we  = '0;
    stat_we = '0;
    ptr_we  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (wr && ch_ok && (ch_idx == CH_W'(c))) begin
        cmd_we[c]  = (sel == SEL_CMD);
        stat_we[c] = (sel == SEL_STAT);
        ptr_we[c]  = (sel == SEL_PTR);
      end
    end
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              stat_we,
  input  logic              ptr_we,
  input  logic [1:0]        lane,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              eng_active,
  input  logic              eng_err_set,
  input  logic              eng_irq_set,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              stop_q
);
  logic run_cleared;

  // a command write that drops a set run bit
  assign run_cleared = cmd_we & cmd_q[CMD_RUN] & ~wdata[CMD_RUN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      ptr_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= cmd_mask(wdata);
      stat_q <= stat_next(stat_q, stat_we, wdata, eng_err_set, eng_irq_set, eng_active);
      if (ptr_we) ptr_q <= ptr_merge(ptr_q, lane, wdata);
      stop_q <= run_cleared;
    end
  end
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int unsigned NCH  = 2,
  parameter int unsigned CH_W = 1
) (
  input  logic [CH_W-1:0]                 ch_idx,
  input  logic                            ch_ok,
  input  reg_sel_e                        sel,
  input  logic [1:0]                      lane,
  input  logic [NCH-1:0][BYTE_W-1:0]      cmd_vec,
  input  logic [NCH-1:0][BYTE_W-1:0]      stat_vec,
  input  logic [NCH-1:0][PTR_W-1:0]       ptr_vec,
  output logic [BYTE_W-1:0]               rdata
);
  always_comb begin
    rdata = '1;
    for (int c = 0; c < NCH; c++) begin
      if (ch_ok && (ch_idx == CH_W'(c))) begin
        case (sel)
          SEL_CMD:  rdata = cmd_vec[c];
          SEL_STAT: rdata = stat_vec[c];
          SEL_PTR:  rdata = ptr_vec[c][lane*BYTE_W +: BYTE_W];
          default:  rdata = '1;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmdma_regbank.sv
module bmdma_regbank
  import bmdma_pkg::*;
#(
  parameter int unsigned NCH = 2,
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned OFF_W = 3,
  localparam int unsigned AW    = CH_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        host_addr,
  input  logic                 host_wr,
  input  logic [BYTE_W-1:0]    host_wdata,
  output logic [BYTE_W-1:0]    host_rdata,
  input  logic [NCH-1:0]       eng_active,
  input  logic [NCH-1:0]       eng_err_set,
  input  logic [NCH-1:0]       eng_irq_set,
  output logic [NCH-1:0]       cmd_run,
  output logic [NCH-1:0]       cmd_dir,
  output logic [NCH-1:0]       cmd_stop,
  output logic [NCH*PTR_W-1:0] tbl_addr
);
  logic [CH_W-1:0] ch_idx;
  logic            ch_ok;
  reg_sel_e        sel;
  logic [1:0]      lane;
  logic [NCH-1:0]  cmd_we, stat_we, ptr_we;

  // per-channel state brought out for the checker
  logic [NCH-1:0][BYTE_W-1:0] cmd_vec;
  logic [NCH-1:0][BYTE_W-1:0] stat_vec;
  logic [NCH-1:0][PTR_W-1:0]  ptr_vec;

  bmdma_decode #(.NCH(NCH), .CH_W(CH_W), .OFF_W(OFF_W)) u_dec (
    .addr    (host_addr),
    .wr      (host_wr),
    .ch_idx  (ch_idx),
    .ch_ok   (ch_ok),
    .sel     (sel),
    .lane    (lane),
    .cmd_we  (cmd_we),
    .stat_we (stat_we),
    .ptr_we  (ptr_we)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      bmdma_chan u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_we      (cmd_we[c]),
        .stat_we     (stat_we[c]),
        .ptr_we      (ptr_we[c]),
        .lane        (lane),
        .wdata       (host_wdata),
        .eng_active  (eng_active[c]),
        .eng_err_set (eng_err_set[c]),
        .eng_irq_set (eng_irq_set[c]),
        .cmd_q       (cmd_vec[c]),
        .stat_q      (stat_vec[c]),
        .ptr_q       (ptr_vec[c]),
        .stop_q      (cmd_stop[c])
      );
      assign cmd_run[c] = cmd_vec[c][CMD_RUN];
      assign cmd_dir[c] = cmd_vec[c][CMD_DIR];
      assign tbl_addr[c*PTR_W +: PTR_W] = ptr_vec[c];
    end
  endgenerate

  bmdma_rdmux #(.NCH(NCH), .CH_W(CH_W)) u_rd (
    .ch_idx   (ch_idx),
    .ch_ok    (ch_ok),
    .sel      (sel),
    .lane     (lane),
    .cmd_vec  (cmd_vec),
    .stat_vec (stat_vec),
    .ptr_vec  (ptr_vec),
    .rdata    (host_rdata)
  );
endmodule

// File: rtl/bmdma_regbank_chk.sv
module bmdma_regbank_chk #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [AW-1:0]         host_addr,
  input logic                  host_wr,
  input logic [NCH-1:0]        eng_active,
  input logic [NCH-1:0]        eng_err_set,
  input logic [NCH-1:0]        eng_irq_set,
  input logic [NCH-1:0]        cmd_stop,
  input logic [NCH-1:0][7:0]   cmd_vec,
  input logic [NCH-1:0][7:0]   stat_vec,
  input logic [NCH-1:0][31:0]  ptr_vec
);
  logic dead_wr;
  assign dead_wr = host_wr && (host_addr[2:0] == 3'd1 || host_addr[2:0] == 3'd3);

  assert_dead_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dead_wr |=> ($stable(cmd_vec) && $stable(ptr_vec)));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_c
      assert_stop_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop[c] |-> ($past(cmd_vec[c][0]) && !cmd_vec[c][0]));

      assert_active_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_vec[c][0] == $past(eng_active[c])));

      assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec[c][7] == 1'b0) && (stat_vec[c][4:3] == 2'b00));

      assert_err_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err_set[c] |=> stat_vec[c][1]);

      assert_irq_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_irq_set[c] |=> stat_vec[c][2]);

      assert_ptr_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_vec[c][1:0] == 2'b00);
    end
  endgenerate
endmodule

bind bmdma_regbank bmdma_regbank_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_addr   (host_addr),
  .host_wr     (host_wr),
  .eng_active  (eng_active),
  .eng_err_set (eng_err_set),
  .eng_irq_set (eng_irq_set),
  .cmd_stop    (cmd_stop),
  .cmd_vec     (cmd_vec),
  .stat_vec    (stat_vec),
  .ptr_vec     (ptr_vec)
);

// File: tb/bmdma_regbank_test.sv
`timescale 1ns/1ps
module bmdma_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [1:0]  eng_active = '0;
  logic [1:0]  eng_err_set = '0;
  logic [1:0]  eng_irq_set = '0;
  logic [1:0]  cmd_run, cmd_dir, cmd_stop;
  logic [63:0] tbl_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bmdma_regbank uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_active(eng_active),
    .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set), .cmd_run(cmd_run),
    .cmd_dir(cmd_dir), .cmd_stop(cmd_stop), .tbl_addr(tbl_addr)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // one-cycle write; returns on the falling edge after the capturing edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    host_addr = a;
    #0.5;
    chk(req, {56'd0, host_rdata}, {56'd0, exp});
  endtask

  task automatic t_reset;
    for (int a = 0; a < 16; a++) begin
      if (a != 1 && a != 3 && a != 9 && a != 11) rd("R1", 4'(a), 8'h00);
    end
    chk("R1 outputs", {58'd0, cmd_run, cmd_dir, cmd_stop}, 64'd0);
    chk("R1 tbl_addr", tbl_addr, 64'd0);
  endtask

  task automatic t_command;
    wr(4'h0, 8'hFF);
    rd("R3 readback", 4'h0, 8'h09);
    chk("R3 run/dir", {62'd0, cmd_run[0], cmd_dir[0]}, 64'd3);
    chk("R4 no pulse on start", {62'd0, cmd_stop}, 64'd0);
  endtask

  task automatic t_dead;
    rd("R2 off1", 4'h1, 8'hFF);
    rd("R2 off3", 4'hB, 8'hFF);
    wr(4'h1, 8'h00);
    wr(4'h3, 8'hFF);
    rd("R2 cmd kept", 4'h0, 8'h09);
    rd("R2 status kept", 4'h2, 8'h00);
    chk("R2 ptr kept", tbl_addr, 64'd0);
  endtask

  task automatic t_stop;
    wr(4'h0, 8'h08);
    chk("R4 pulse", {62'd0, cmd_stop}, 64'd1);
    @(negedge clk);
    chk("R4 pulse one cycle", {62'd0, cmd_stop}, 64'd0);
    rd("R3 dir only", 4'h0, 8'h08);
    wr(4'h0, 8'h00);
    chk("R4 no pulse when idle", {62'd0, cmd_stop}, 64'd0);
  endtask

  task automatic t_stat_rw;
    wr(4'h2, 8'hFF);
    rd("R5 R8 set 6:5", 4'h2, 8'h60);
    wr(4'h2, 8'h9F);
    rd("R5 clear 6:5", 4'h2, 8'h00);
  endtask

  task automatic t_w1c;
    @(negedge clk); eng_err_set = 2'b01;
    @(negedge clk); eng_err_set = 2'b00;
    rd("R9 err set", 4'h2, 8'h02);
    eng_irq_set = 2'b01;
    @(negedge clk); eng_irq_set = 2'b00;
    rd("R9 irq set", 4'h2, 8'h06);
    wr(4'h2, 8'h00);
    rd("R6 zero keeps", 4'h2, 8'h06);
    wr(4'h2, 8'h04);
    rd("R6 clear irq", 4'h2, 8'h02);
    @(negedge clk);
    host_addr = 4'h2; host_wdata = 8'h02; host_wr = 1'b1; eng_err_set = 2'b01;
    @(negedge clk);
    host_wr = 1'b0; eng_err_set = 2'b00;
    rd("R9 set beats clear", 4'h2, 8'h02);
    wr(4'h2, 8'h02);
    rd("R6 clear err", 4'h2, 8'h00);
  endtask

  task automatic t_active;
    @(negedge clk); eng_active = 2'b01;
    @(negedge clk);
    rd("R7 mirror high", 4'h2, 8'h01);
    wr(4'h2, 8'h00);
    rd("R7 write ignored", 4'h2, 8'h01);
    eng_active = 2'b00;
    @(negedge clk);
    rd("R7 mirror low", 4'h2, 8'h00);
  endtask

  task automatic t_ptr;
    wr(4'h4, 8'h7B);
    wr(4'h5, 8'h56);
    wr(4'h6, 8'h34);
    wr(4'h7, 8'h12);
    chk("R10 tbl_addr", {32'd0, tbl_addr[31:0]}, 64'h12345678);
    rd("R10 byte0 aligned", 4'h4, 8'h78);
    rd("R10 byte3", 4'h7, 8'h12);
  endtask

  task automatic t_iso;
    wr(4'h8, 8'h01);
    wr(4'hC, 8'hFF);
    wr(4'hA, 8'h20);
    chk("R11 ch1 run", {62'd0, cmd_run}, 64'd2);
    rd("R11 ch0 cmd", 4'h0, 8'h00);
    chk("R11 ch1 ptr", tbl_addr, 64'h000000FC_12345678);
    rd("R11 ch1 stat", 4'hA, 8'h20);
    rd("R11 ch0 stat", 4'h2, 8'h00);
    @(negedge clk); eng_err_set = 2'b10;
    @(negedge clk); eng_err_set = 2'b00;
    rd("R11 ch1 err", 4'hA, 8'h22);
    rd("R11 ch0 untouched", 4'h2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_command();
    t_dead();
    t_stop();
    t_stat_rw();
    t_w1c();
    t_active();
    t_ptr();
    t_iso();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule